// File: doc/BRIEF.md
# Occupancy-Based Packet Merge Arbiter

This block is the merge stage at one output port of a packet switch. Four input-queued lanes offer flits to a single output channel. Each lane presents a valid bit, the flit at the front of its queue and a count of how many entries its queue holds. The arbiter favours the lane with the fullest queue, so the most congested input drains first. If that lane has nothing to send, it falls back to another lane that does.

A packet is a head flit followed by a number of body flits. The head flit carries that number. Once a head flit wins, its lane owns the output until all of its body flits have moved. Only then is a new winner picked. Flow control on both sides uses a valid bit plus a backpressure bit. The output is registered, and it holds its contents while the downstream side pushes back.

Top module: `omerge_top`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), out_valid is 0, no packet is locked and the remembered lane is 0. With no lane valid and out_bp low, lane_bp is 4'b1110.
- R2: When unlocked and lane 0 is valid, lane 0 beats lane 1 whenever occ0 >= occ1. On equal counts everywhere, lane 0 is granted.
- R3: Lanes 2 and 3 are then compared in index order. Each replaces the running winner only if its count is strictly greater, so the granted lane is the lowest index holding the maximum count.
- R4: If the lane chosen by counts is not valid, the grant goes to the highest-indexed valid lane.
- R5: A head flit has bit 15 = 1 and carries its body length L in bits 3:0. Body flits have bit 15 = 0. Once a head with L > 0 transfers, the same lane stays granted for exactly L more transfers, whatever the counts and valid bits.
- R6: lane_bp[i] is 1 for every lane not granted. For the granted lane, lane_bp equals out_bp. A transfer happens when the granted lane is valid and out_bp is 0.
- R7: While out_bp is 1, out_valid and out_data keep their values at the next edge.
- R8: When no lane is valid and no packet is locked, the grant (the single lane with lane_bp low) stays on the lane that transferred last, and out_valid is 0 one cycle later.
- R9: A flit transferred at a clock edge appears on out_data with out_valid high right after that edge.
- R10: A head flit with L = 0 is a complete packet. Arbitration resumes on the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lane_valid | input | 4 | Per-lane flit available |
| lane_data | input | 64 | Per-lane front flit, lane i in bits 16i+15:16i |
| lane_occ | input | 16 | Per-lane queue occupancy, lane i in bits 4i+3:4i |
| lane_bp | output | 4 | Per-lane backpressure, 1 = hold |
| out_valid | output | 1 | Output flit valid |
| out_data | output | 16 | Output flit |
| out_bp | input | 1 | Downstream backpressure, 1 = hold |

## Verification
The grant and lane_bp depend on the inputs through logic only, so they are due in the same cycle the inputs are applied. The bench drives each cycle's inputs just after a falling edge and compares lane_bp one time unit later. A transfer reaches out_valid and out_data one edge later, and the lock state advances at that same edge. The bench's reference model therefore computes the next-state output from the current cycle's inputs and compares it at the following falling edge, which is half a period clear of the edge that loaded it.

// File: rtl/omerge_pkg.sv
// Shared types for the occupancy-based merge arbiter.
package omerge_pkg;

    // Packet ownership state of the output channel.
    typedef enum logic {
        ARB_OPEN   = 1'b0,
        ARB_LOCKED = 1'b1
    } lock_state_e;

endpackage

// File: rtl/omerge_occ_pick.sv
// Occupancy comparison and fallback selection.
// Does: scans the lanes in index order, keeping the running winner unless a
//       later lane has a strictly larger count; if the winner is not valid,
//       picks the highest valid lane; with no lane valid, returns cur_sel.
// Assumes: lane_occ packs lane i at bits [i*OCC_W +: OCC_W].
module omerge_occ_pick #(
    parameter int N_LANES = 4,
    parameter int OCC_W   = 4,
    parameter int IDX_W   = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_LANES-1:0]       lane_valid,
    input  logic [N_LANES*OCC_W-1:0] lane_occ,
    input  logic [IDX_W-1:0]         cur_sel,
    output logic [IDX_W-1:0]         pick_idx
);

    logic [IDX_W-1:0] best_idx;
    logic [OCC_W-1:0] best_occ;
    logic [IDX_W-1:0] top_valid_idx;
    logic             any_valid;

    // Comparison chain: the earlier lane wins ties.
    always_comb begin
        best_idx = '0;
        best_occ = lane_occ[OCC_W-1:0];
        for (int k = 1; k < N_LANES; k++) begin
            if (lane_occ[k*OCC_W +: OCC_W] > best_occ) begin
                best_occ = lane_occ[k*OCC_W +: OCC_W];
                best_idx = IDX_W'(k);
            end
        end
    end

    // Fallback search: the highest valid index.
    always_comb begin
        top_valid_idx = '0;
        any_valid     = 1'b0;
        for (int k = 0; k < N_LANES; k++) begin
            if (lane_valid[k]) begin
                top_valid_idx = IDX_W'(k);
                any_valid     = 1'b1;
            end
        end
    end

    // Final choice: winner, fallback or kept selection.
    always_comb begin
        if (!any_valid)
            pick_idx = cur_sel;
        else if (lane_valid[best_idx])
            pick_idx = best_idx;
        else
            pick_idx = top_valid_idx;
    end

    // R4: whenever any lane has data, the picked lane has data.
    a_r4_pick_is_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (|lane_valid) |-> lane_valid[pick_idx]);

endmodule

// File: rtl/omerge_pkt_lock.sv
// Packet lock tracker.
// Does: remembers the lane of the last transfer. After a head flit with a
//       non-zero body length transfers, it holds that lane until the same
//       number of further transfers have happened.
// Assumes: xfer is only raised for the lane given on grant_idx.
module omerge_pkt_lock
    import omerge_pkg::*;
#(
    parameter int LEN_W = 4,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xfer,
    input  logic             xfer_head,
    input  logic [LEN_W-1:0] xfer_len,
    input  logic [IDX_W-1:0] grant_idx,
    output logic             locked,
    output logic [IDX_W-1:0] sel_idx
);

    lock_state_e      state;
    logic [LEN_W-1:0] remain;

    // Lock state, remaining body count and remembered lane.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ARB_OPEN;
            remain  <= '0;
            sel_idx <= '0;
        end else if (xfer) begin
            if (state == ARB_OPEN) begin
                sel_idx <= grant_idx;
                if (xfer_head && (xfer_len != '0)) begin
                    state  <= ARB_LOCKED;
                    remain <= xfer_len;
                end
            end else begin
                remain <= remain - 1'b1;
                if (remain == LEN_W'(1))
                    state <= ARB_OPEN;
            end
        end
    end

    assign locked = (state == ARB_LOCKED);

    // R5: a locked packet keeps its lane until the last body flit moves.
    a_r5_lock_holds_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !(xfer && remain == LEN_W'(1))) |=> (locked && $stable(sel_idx)));

    // R5: a locked state always has body flits outstanding.
    a_r5_remain_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> (remain != '0));

endmodule

// File: rtl/omerge_out_stage.sv
// Output register of the merge channel.
// Does: loads the transferred flit. It holds while downstream pushes back,
//       and it drops valid on an idle cycle.
// Assumes: xfer is already masked by out_bp.
module omerge_out_stage #(
    parameter int FLIT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer,
    input  logic [FLIT_W-1:0] flit,
    input  logic              out_bp,
    output logic              out_valid,
    output logic [FLIT_W-1:0] out_data
);

    // Register the flit when downstream accepts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (!out_bp) begin
            out_valid <= xfer;
            if (xfer)
                out_data <= flit;
        end
    end

    // R7: backpressure freezes the output register.
    a_r7_hold_on_bp: assert property (@(posedge clk) disable iff (!rst_n)
        out_bp |=> ($stable(out_valid) && $stable(out_data)));

    // R8: an accepted cycle with no transfer leaves the output empty.
    a_r8_idle_drops_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_bp && !xfer) |=> !out_valid);

endmodule

// File: rtl/omerge_top.sv
// Occupancy-based packet merge arbiter, top level.
// Does: grants one of N_LANES lanes to a registered output channel. A new
//       lane is chosen only at packet boundaries, by queue occupancy.
// Assumes: head flits carry a 1 in the MSB and the body length in the low
//          LEN_W bits; lanes only present head flits between packets.
module omerge_top #(
    parameter int N_LANES = 4,
    parameter int FLIT_W  = 16,
    parameter int OCC_W   = 4,
    parameter int LEN_W   = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_LANES-1:0]        lane_valid,
    input  logic [N_LANES*FLIT_W-1:0] lane_data,
    input  logic [N_LANES*OCC_W-1:0]  lane_occ,
    output logic [N_LANES-1:0]        lane_bp,
    output logic                      out_valid,
    output logic [FLIT_W-1:0]         out_data,
    input  logic                      out_bp
);

    localparam int IDX_W = (N_LANES > 1) ? $clog2(N_LANES) : 1;

    logic [IDX_W-1:0]  pick_idx;
    logic [IDX_W-1:0]  sel_idx;
    logic [IDX_W-1:0]  grant_idx;
    logic              locked;
    logic              xfer;
    logic [FLIT_W-1:0] grant_flit;

    omerge_occ_pick #(
        .N_LANES (N_LANES),
        .OCC_W   (OCC_W),
        .IDX_W   (IDX_W)
    ) pick_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .lane_valid (lane_valid),
        .lane_occ   (lane_occ),
        .cur_sel    (sel_idx),
        .pick_idx   (pick_idx)
    );

    // Grant: the locked lane, otherwise the fresh pick.
    assign grant_idx  = locked ? sel_idx : pick_idx;
    assign grant_flit = lane_data[grant_idx*FLIT_W +: FLIT_W];
    assign xfer       = lane_valid[grant_idx] && !out_bp;

    // Per-lane backpressure: closed unless granted and downstream open.
    for (genvar i = 0; i < N_LANES; i++) begin : g_lane_bp
        assign lane_bp[i] = (grant_idx != IDX_W'(i)) || out_bp;
    end

    omerge_pkt_lock #(
        .LEN_W (LEN_W),
        .IDX_W (IDX_W)
    ) lock_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .xfer      (xfer),
        .xfer_head (grant_flit[FLIT_W-1]),
        .xfer_len  (grant_flit[LEN_W-1:0]),
        .grant_idx (grant_idx),
        .locked    (locked),
        .sel_idx   (sel_idx)
    );

    omerge_out_stage #(
        .FLIT_W (FLIT_W)
    ) out_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .xfer      (xfer),
        .flit      (grant_flit),
        .out_bp    (out_bp),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    // R6: at most one lane is ever released.
    a_r6_single_open_lane: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~lane_bp) <= 1);

    // R9: an accepted transfer shows up as valid output after one edge.
    a_r9_xfer_to_output: assert property (@(posedge clk) disable iff (!rst_n)
        xfer |=> out_valid);

endmodule

// File: tb/omerge_top_tb_top.sv
`timescale 1ns/1ps
module omerge_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  lane_valid = '0;
    logic [63:0] lane_data = '0;
    logic [15:0] lane_occ = '0;
    logic [3:0]  lane_bp;
    logic        out_valid;
    logic [15:0] out_data;
    logic        out_bp = 1'b0;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    omerge_top dut_i (
        .clk(clk), .rst_n(rst_n), .lane_valid(lane_valid), .lane_data(lane_data),
        .lane_occ(lane_occ), .lane_bp(lane_bp), .out_valid(out_valid),
        .out_data(out_data), .out_bp(out_bp)
    );

    // Reference model state
    bit       m_locked = 0;
    int       m_remain = 0;
    int       m_sel = 0;
    bit       e_ov = 0;
    bit       e_prev_bp = 0;
    bit       m_single = 0;
    logic [15:0] e_od = '0;

    // Lane packet generators
    int body_left [4];
    int seq [4];
    int next_len [4];

    function automatic logic [15:0] front(int i);
        if (body_left[i] == 0)
            return {1'b1, 2'(i), 9'(seq[i]), 4'(next_len[i])};
        return {1'b0, 2'(i), 9'(seq[i]), 4'(body_left[i])};
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // One cycle: check registered outputs, apply inputs, check lane_bp, step model.
    task automatic step(logic [3:0] v, logic [15:0] occ, logic bp);
        int best, bestocc, top, grant;
        bit any, x;
        logic [15:0] f;
        string tag;
        @(negedge clk);
        cycles++;
        chk(out_valid == e_ov, e_prev_bp ? "R7 out_valid" : "R9 out_valid", out_valid, e_ov);
        if (e_ov) chk(out_data == e_od, e_prev_bp ? "R7 out_data" : "R9 out_data", out_data, e_od);
        lane_valid = v;
        lane_occ = occ;
        out_bp = bp;
        for (int i = 0; i < 4; i++) lane_data[i*16 +: 16] = front(i);
        #1;
        best = 0; bestocc = -1; top = 0; any = 0;
        for (int i = 0; i < 4; i++) begin
            if (int'(occ[i*4 +: 4]) > bestocc) begin bestocc = occ[i*4 +: 4]; best = i; end
            if (v[i]) begin top = i; any = 1; end
        end
        if (m_locked) begin grant = m_sel; tag = "R5"; end
        else if (!any) begin grant = m_sel; tag = "R8"; end
        else if (!v[best]) begin grant = top; tag = "R4"; end
        else begin grant = best; tag = (best == 0) ? "R2" : "R3"; end
        if (!m_locked && m_single) tag = {tag, " R10"};
        for (int i = 0; i < 4; i++) begin
            bit eb;
            eb = (i != grant) || bp;
            chk(lane_bp[i] == eb, {tag, " R6 lane_bp"}, lane_bp, i);
        end
        x = v[grant] && !bp;
        f = front(grant);
        e_prev_bp = bp;
        if (!bp) begin
            e_ov = x;
            if (x) e_od = f;
        end
        if (x) begin
            if (!m_locked) begin
                m_sel = grant;
                m_single = f[15] && (f[3:0] == 0);
                if (f[15] && f[3:0] != 0) begin m_locked = 1; m_remain = f[3:0]; end
            end else begin
                m_single = 0;
                m_remain--;
                if (m_remain == 0) m_locked = 0;
            end
            if (body_left[grant] == 0) begin
                body_left[grant] = next_len[grant];
                next_len[grant] = $urandom % 4;
                seq[grant]++;
            end else begin
                body_left[grant]--;
            end
        end
    endtask

    initial begin
        for (int i = 0; i < 4; i++) begin body_left[i] = 0; seq[i] = i * 16; next_len[i] = i; end
        next_len[1] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
        chk(lane_bp == 4'b1110, "R1 lane_bp", lane_bp, 4'he);
        // R2: equal counts, all valid
        repeat (12) step(4'hf, 16'h5555, 0);
        // R3: later lanes with strictly larger counts
        repeat (12) step(4'hf, 16'h7755, 0);
        repeat (12) step(4'hf, 16'h9777, 0);
        // R4: winner invalid, fallback to highest valid
        repeat (12) step(4'b1010, 16'h111f, 0);
        // R8: idle, selection kept
        repeat (6) step(4'h0, 16'h0000, 0);
        // R7: downstream backpressure held then released
        repeat (4) step(4'hf, 16'h3210, 1);
        repeat (10) step(4'hf, 16'h3210, 0);
        repeat (6) step(4'hf, 16'h0123, 1);
        // R10 and mixed traffic
        for (int n = 0; n < 3000; n++)
            step(4'($urandom), 16'($urandom), ($urandom % 4) == 0);
        repeat (8) step(4'h0, 16'h0000, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #100000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule